// File: doc/BRIEF.md
# SPI FIFO and Level-Trigger Interrupt Controller

This block holds the transmit and receive word queues of a serial peripheral controller, along with the interrupt logic built on their fill levels. Software reaches it through a simple register read/write port. A write to the transmit-data address queues a word for the shift engine. A read from the receive-data address returns and removes the oldest received word. The shift engine, which is outside this block, pops transmit words and pushes received words through dedicated word ports.

Four interrupt sources are tracked: receive overflow, receive timeout, receive level and transmit level. The two level sources follow queue occupancy against programmable power-of-two thresholds, and they compare in opposite senses. The two error sources latch and stay set until software writes a clear. A mask register gates the raw sources into the masked status, and a single interrupt output is the OR of the masked bits. Clearing the enable bit empties both queues.

Register addresses (word index on `reg_addr`): 0 control (bit 0 enable), 1 trigger levels, 2 interrupt mask, 3 transmit data (write), 4 receive data (read), 5 status, 6 raw interrupts, 7 masked interrupts, 8 interrupt clear, 9 timeout limit (clocks).

Top module: `spi_fifo_irq_ctrl`

## Requirements
- R1: After reset the status reads 5'b00011, the mask reads 4'hF, the raw interrupt register reads 4'b1000 and `irq` is low.
- R2: Words written to address 3 leave on `eng_tx_data` in write order, one per `eng_tx_pop`. Status bit 0 (transmit empty) reads 1 only when nothing is queued.
- R3: Words pushed on `eng_rx_push` are returned in arrival order by reads of address 4. Status bit 2 (receive not empty) is 1 while any word is held.
- R4: Status bit 3 reads 1 when the receive queue holds DEPTH words. Status bit 1 (transmit not full) reads 0 when the transmit queue holds DEPTH words.
- R5: A push on `eng_rx_push` while the receive queue is full sets raw bit 0 (overflow), and the word is dropped.
- R6: Writing 1 to bit 0 or bit 1 of address 8 clears raw bit 0 or bit 1. Writing bits 2 and 3 there does not change the level bits.
- R7: Raw bit 3 (transmit level) is 1 whenever the transmit occupancy is at or below the level chosen by trigger bits 5:3. Codes 0..6 select 1, 4, 8, 16, 32, 64 and 128 words.
- R8: Raw bit 2 (receive level) is 1 whenever the receive occupancy is at or above the level chosen by trigger bits 11:9, using the same code table.
- R9: Trigger code 7 selects 128 words, the same level as code 6.
- R10: Address 7 reads raw AND NOT mask (a mask bit of 1 blocks its source), and `irq` is the OR of those bits.
- R11: Raw bit 1 (timeout) sets once the receive queue has been non-empty, below its trigger and free of push and pop for the limit in address 9 clocks. A limit of 0 disables it.
- R12: While control bit 0 is 0 both queues are emptied, so status reads 5'b00011 with the engine idle.
- R13: Status bit 4 (busy) is 1 while `eng_busy` is high or the transmit queue is not empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops on address 4) |
| reg_addr | input | 4 | Register word index |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data, valid in the cycle of `reg_rd` |
| eng_tx_pop | input | 1 | Engine takes the head transmit word |
| eng_tx_data | output | DATA_W | Head transmit word |
| eng_tx_avail | output | 1 | Transmit queue not empty |
| eng_rx_push | input | 1 | Engine delivers a received word |
| eng_rx_data | input | DATA_W | Received word |
| eng_busy | input | 1 | Engine is shifting |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with DEPTH set to 16 and DATA_W set to 32. At that depth the full and overflow conditions, and the 1, 4, 8 and 16-word thresholds, each take only a few register operations to reach. With the queue holding at most 16 words, codes 6 and 7 can only be judged by the transmit source, which stays active up to 128 words, so that source carries the check. The timeout limit is programmed to 10 clocks so the expiry edge falls inside a short window.

// File: rtl/sfic_pkg.sv
package sfic_pkg;
  localparam int ADDR_W = 4;

  localparam logic [ADDR_W-1:0] A_CTRL = 4'd0;
  localparam logic [ADDR_W-1:0] A_TRIG = 4'd1;
  localparam logic [ADDR_W-1:0] A_MASK = 4'd2;
  localparam logic [ADDR_W-1:0] A_TXD  = 4'd3;
  localparam logic [ADDR_W-1:0] A_RXD  = 4'd4;
  localparam logic [ADDR_W-1:0] A_STAT = 4'd5;
  localparam logic [ADDR_W-1:0] A_RAW  = 4'd6;
  localparam logic [ADDR_W-1:0] A_MSKD = 4'd7;
  localparam logic [ADDR_W-1:0] A_CLR  = 4'd8;
  localparam logic [ADDR_W-1:0] A_TOUT = 4'd9;

  // trigger field positions (decoded by software, kept fixed)
  localparam int TX_TRIG_LSB = 3;
  localparam int RX_TRIG_LSB = 9;

  // threshold in words for a 3-bit trigger code; 7 aliases 6
  function automatic int unsigned trig_words(input logic [2:0] code);
    int unsigned w;
    if (code == 3'd0)      w = 1;
    else if (code >= 3'd6) w = 128;
    else                   w = 32'd1 << (code + 3'd1);
    return w;
  endfunction
endpackage

// File: rtl/sfic_fifo.sv
module sfic_fifo #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 256,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              push,
  input  logic [DATA_W-1:0] wdata,
  input  logic              pop,
  output logic [DATA_W-1:0] rdata,
  output logic [CNT_W-1:0]  count,
  output logic              full,
  output logic              empty
);
  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wr_ptr_q, wr_ptr_n, rd_ptr_q, rd_ptr_n;
  logic [CNT_W-1:0]  cnt_q, cnt_n;
  logic              do_push, do_pop;

  assign full    = (cnt_q == CNT_W'(DEPTH));
  assign empty   = (cnt_q == '0);
  assign count   = cnt_q;
  assign rdata   = mem[rd_ptr_q];
  assign do_push = push & ~full & ~flush;
  assign do_pop  = pop & ~empty & ~flush;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    wr_ptr_n = wr_ptr_q;
    rd_ptr_n = rd_ptr_q;
    cnt_n    = cnt_q;
    if (flush) begin
      wr_ptr_n = '0;
      rd_ptr_n = '0;
      cnt_n    = '0;
    end else begin
      if (do_push) wr_ptr_n = bump(wr_ptr_q);
      if (do_pop)  rd_ptr_n = bump(rd_ptr_q);
      case ({do_push, do_pop})
        2'b10:   cnt_n = cnt_q + 1'b1;
        2'b01:   cnt_n = cnt_q - 1'b1;
        default: cnt_n = cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      wr_ptr_q <= wr_ptr_n;
      rd_ptr_q <= rd_ptr_n;
      cnt_q    <= cnt_n;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr_q] <= wdata;
  end
endmodule

// File: rtl/sfic_irq.sv
module sfic_irq
  import sfic_pkg::*;
#(
  parameter int CNT_W = 9,
  parameter int TO_W  = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [CNT_W-1:0] rx_count,
  input  logic [CNT_W-1:0] tx_count,
  input  logic [2:0]       rx_code,
  input  logic [2:0]       tx_code,
  input  logic             rx_push,
  input  logic             rx_pop,
  input  logic             rx_full,
  input  logic [3:0]       mask,
  input  logic [1:0]       clr,
  input  logic [TO_W-1:0]  to_limit,
  output logic [3:0]       raw,
  output logic [3:0]       masked,
  output logic             irq
);
  logic            ovf_q, ovf_n, to_q, to_n;
  logic [TO_W-1:0] tcnt_q, tcnt_n;
  logic            rx_lvl, tx_lvl, idle, set_to, set_ovf;

  assign rx_lvl = 32'(rx_count) >= trig_words(rx_code);
  assign tx_lvl = 32'(tx_count) <= trig_words(tx_code);

  always_comb begin
    idle    = en & (rx_count != '0) & ~rx_push & ~rx_pop & ~rx_lvl
              & (to_limit != '0);
    tcnt_n  = '0;
    if (idle) tcnt_n = (tcnt_q == to_limit) ? tcnt_q : tcnt_q + 1'b1;
    set_to  = idle & (tcnt_n == to_limit);
    set_ovf = en & rx_push & rx_full;
    ovf_n   = set_ovf | (ovf_q & ~clr[0]);
    to_n    = set_to | (to_q & ~clr[1]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovf_q  <= 1'b0;
      to_q   <= 1'b0;
      tcnt_q <= '0;
    end else begin
      ovf_q  <= ovf_n;
      to_q   <= to_n;
      tcnt_q <= tcnt_n;
    end
  end

  assign raw    = {tx_lvl, rx_lvl, to_q, ovf_q};
  assign masked = raw & ~mask;
  assign irq    = |masked;
endmodule

// File: rtl/spi_fifo_irq_ctrl.sv
module spi_fifo_irq_ctrl
  import sfic_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int DEPTH     = 256,
  parameter int TO_W      = 16,
  parameter int TO_RESET  = 64,
  localparam int CNT_W    = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [3:0]        reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              eng_tx_pop,
  output logic [DATA_W-1:0] eng_tx_data,
  output logic              eng_tx_avail,
  input  logic              eng_rx_push,
  input  logic [DATA_W-1:0] eng_rx_data,
  input  logic              eng_busy,
  output logic              irq
);
  logic            ctrl_en_q, ctrl_en_n;
  logic [2:0]      tx_code_q, tx_code_n, rx_code_q, rx_code_n;
  logic [3:0]      mask_q, mask_n;
  logic [TO_W-1:0] to_lim_q, to_lim_n;

  logic              tx_push, rx_pop, clr_we;
  logic [1:0]        clr_bits;
  logic [CNT_W-1:0]  tx_count, rx_count;
  logic              tx_full, tx_empty, rx_full, rx_empty;
  logic [DATA_W-1:0] rx_head;
  logic [3:0]        raw_w, masked_w;
  logic [4:0]        status;

  assign tx_push  = reg_wr & (reg_addr == A_TXD);
  assign rx_pop   = reg_rd & (reg_addr == A_RXD);
  assign clr_we   = reg_wr & (reg_addr == A_CLR);
  assign clr_bits = clr_we ? reg_wdata[1:0] : 2'b00;

  // register next-state
  always_comb begin
    ctrl_en_n = ctrl_en_q;
    tx_code_n = tx_code_q;
    rx_code_n = rx_code_q;
    mask_n    = mask_q;
    to_lim_n  = to_lim_q;
    if (reg_wr) begin
      case (reg_addr)
        A_CTRL: ctrl_en_n = reg_wdata[0];
        A_TRIG: begin
          tx_code_n = reg_wdata[TX_TRIG_LSB +: 3];
          rx_code_n = reg_wdata[RX_TRIG_LSB +: 3];
        end
        A_MASK: mask_n   = reg_wdata[3:0];
        A_TOUT: to_lim_n = reg_wdata[TO_W-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_en_q <= 1'b0;
      tx_code_q <= 3'd0;
      rx_code_q <= 3'd0;
      mask_q    <= 4'hF;
      to_lim_q  <= TO_W'(TO_RESET);
    end else begin
      ctrl_en_q <= ctrl_en_n;
      tx_code_q <= tx_code_n;
      rx_code_q <= rx_code_n;
      mask_q    <= mask_n;
      to_lim_q  <= to_lim_n;
    end
  end

  sfic_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_tx_fifo (
    .clk(clk), .rst_n(rst_n), .flush(~ctrl_en_q),
    .push(tx_push), .wdata(reg_wdata),
    .pop(eng_tx_pop), .rdata(eng_tx_data),
    .count(tx_count), .full(tx_full), .empty(tx_empty)
  );

  sfic_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_rx_fifo (
    .clk(clk), .rst_n(rst_n), .flush(~ctrl_en_q),
    .push(eng_rx_push), .wdata(eng_rx_data),
    .pop(rx_pop), .rdata(rx_head),
    .count(rx_count), .full(rx_full), .empty(rx_empty)
  );

  sfic_irq #(.CNT_W(CNT_W), .TO_W(TO_W)) u_irq (
    .clk(clk), .rst_n(rst_n), .en(ctrl_en_q),
    .rx_count(rx_count), .tx_count(tx_count),
    .rx_code(rx_code_q), .tx_code(tx_code_q),
    .rx_push(eng_rx_push), .rx_pop(rx_pop), .rx_full(rx_full),
    .mask(mask_q), .clr(clr_bits), .to_limit(to_lim_q),
    .raw(raw_w), .masked(masked_w), .irq(irq)
  );

  assign eng_tx_avail = ~tx_empty;
  assign status = {eng_busy | ~tx_empty, rx_full, ~rx_empty, ~tx_full, tx_empty};

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_CTRL: reg_rdata = DATA_W'(ctrl_en_q);
      A_TRIG: begin
        reg_rdata[TX_TRIG_LSB +: 3] = tx_code_q;
        reg_rdata[RX_TRIG_LSB +: 3] = rx_code_q;
      end
      A_MASK: reg_rdata = DATA_W'(mask_q);
      A_RXD:  reg_rdata = rx_head;
      A_STAT: reg_rdata = DATA_W'(status);
      A_RAW:  reg_rdata = DATA_W'(raw_w);
      A_MSKD: reg_rdata = DATA_W'(masked_w);
      A_TOUT: reg_rdata = DATA_W'(to_lim_q);
      default: reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/sfic_checker.sv
module sfic_checker #(
  parameter int DEPTH = 256,
  parameter int CNT_W = 9
) (
  input logic             clk,
  input logic             rst_n,
  input logic             en,
  input logic [3:0]       raw,
  input logic [3:0]       mask,
  input logic             irq,
  input logic [CNT_W-1:0] rx_count,
  input logic [CNT_W-1:0] tx_count,
  input logic             rx_push,
  input logic             rx_pop,
  input logic             rx_full,
  input logic [1:0]       clr
);
  assert_ovf_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
    en && rx_push && rx_full |=> raw[0]);

  assert_ovf_drop_R5: assert property (@(posedge clk) disable iff (!rst_n)
    en && rx_push && rx_full && !rx_pop |=> $stable(rx_count));

  assert_ovf_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    raw[0] && !clr[0] |=> raw[0]);

  assert_flush_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (rx_count == '0) && (tx_count == '0));

  assert_irq_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (mask == 4'hF) |-> !irq);

  assert_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (32'(rx_count) <= DEPTH) && (32'(tx_count) <= DEPTH));
endmodule

bind spi_fifo_irq_ctrl sfic_checker #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .en(ctrl_en_q), .raw(raw_w), .mask(mask_q),
  .irq(irq), .rx_count(rx_count), .tx_count(tx_count),
  .rx_push(eng_rx_push), .rx_pop(rx_pop), .rx_full(rx_full), .clr(clr_bits)
);

// File: tb/spi_fifo_irq_ctrl_test.sv
`timescale 1ns/1ps
module spi_fifo_irq_ctrl_test;
  localparam int DW = 32;
  localparam int DEPTH = 16;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          reg_wr, reg_rd, eng_tx_pop, eng_rx_push, eng_busy;
  logic [3:0]    reg_addr;
  logic [DW-1:0] reg_wdata, reg_rdata, eng_tx_data, eng_rx_data;
  logic          eng_tx_avail, irq;

  int checks = 0, failures = 0;
  logic [DW-1:0] rx_exp[$];
  logic [DW-1:0] tx_exp[$];
  int m_rx = 0, m_tx = 0;
  logic [DW-1:0] mon_word;
  string         mon_req;
  event          rx_seen, tx_seen;

  always #2.5 clk = ~clk;

  spi_fifo_irq_ctrl #(.DATA_W(DW), .DEPTH(DEPTH)) uut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .eng_tx_pop(eng_tx_pop), .eng_tx_data(eng_tx_data),
    .eng_tx_avail(eng_tx_avail), .eng_rx_push(eng_rx_push),
    .eng_rx_data(eng_rx_data), .eng_busy(eng_busy), .irq(irq)
  );

  task automatic check(input bit ok, input string req, input logic [DW-1:0] act,
                       input logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [DW-1:0] d);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    #1 d = reg_rdata;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic expect_reg(input logic [3:0] a, input logic [DW-1:0] e,
                            input string req);
    logic [DW-1:0] v;
    rd(a, v);
    check(v == e, req, v, e);
  endtask

  // driver: transmit word from software side
  task automatic tx_write(input logic [DW-1:0] d);
    wr(4'd3, d);
    if (m_tx < DEPTH) begin tx_exp.push_back(d); m_tx++; end
  endtask

  // driver: engine delivers a received word
  task automatic rx_deliver(input logic [DW-1:0] d);
    @(negedge clk);
    eng_rx_push = 1'b1; eng_rx_data = d;
    @(negedge clk);
    eng_rx_push = 1'b0;
    if (m_rx < DEPTH) begin rx_exp.push_back(d); m_rx++; end
  endtask

  task automatic rx_read(input string req);
    logic [DW-1:0] v;
    rd(4'd4, v);
    mon_word = v; mon_req = req;
    ->rx_seen;
    #0;
  endtask

  task automatic tx_take(input string req);
    @(negedge clk);
    #1 mon_word = eng_tx_data; mon_req = req;
    ->tx_seen;
    eng_tx_pop = 1'b1;
    @(negedge clk);
    eng_tx_pop = 1'b0;
  endtask

  // monitor: compare produced words against the scoreboard queues
  always @(rx_seen) begin
    logic [DW-1:0] e;
    e = (rx_exp.size() > 0) ? rx_exp.pop_front() : 'x;
    if (m_rx > 0) m_rx--;
    check(mon_word === e, mon_req, mon_word, e);
  end

  always @(tx_seen) begin
    logic [DW-1:0] e;
    e = (tx_exp.size() > 0) ? tx_exp.pop_front() : 'x;
    if (m_tx > 0) m_tx--;
    check(mon_word === e, mon_req, mon_word, e);
  end

  initial begin
    #(200000 * 5);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [DW-1:0] v;
    rst_n = 1'b0; reg_wr = 0; reg_rd = 0; reg_addr = 0; reg_wdata = 0;
    eng_tx_pop = 0; eng_rx_push = 0; eng_rx_data = 0; eng_busy = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    expect_reg(4'd5, 32'h03, "R1 status");
    expect_reg(4'd2, 32'hF, "R1 mask");
    expect_reg(4'd6, 32'h8, "R1 raw");
    check(irq == 1'b0, "R1 irq", DW'(irq), 0);

    wr(4'd0, 1);
    wr(4'd1, (32'd1 << 3) | (32'd2 << 9));   // tx code 1 (4), rx code 2 (8)

    // R10 masking
    wr(4'd2, 32'h7);
    @(negedge clk);
    check(irq == 1'b1, "R10 irq unmasked tx level", DW'(irq), 1);
    expect_reg(4'd7, 32'h8, "R10 masked status");
    wr(4'd2, 32'hF);
    @(negedge clk);
    check(irq == 1'b0, "R10 irq all masked", DW'(irq), 0);
    expect_reg(4'd7, 32'h0, "R10 masked zero");

    // R2 / R7 transmit order and level
    for (int i = 0; i < 4; i++) tx_write(32'hA0 + i);
    rd(4'd6, v); check(v[3] == 1'b1, "R7 tx level at 4", v, 32'h8);
    tx_write(32'hA4);
    rd(4'd6, v); check(v[3] == 1'b0, "R7 tx level above 4", v, 0);
    rd(4'd5, v); check(v[0] == 1'b0 && v[4] == 1'b1, "R2 R13 status tx queued", v, 32'h12);
    for (int i = 0; i < 5; i++) tx_take("R2 tx order");
    rd(4'd5, v); check(v[0] == 1'b1, "R2 tx empty after drain", v, 32'h1);

    // R13 busy from engine
    eng_busy = 1'b1;
    rd(4'd5, v); check(v[4] == 1'b1, "R13 busy set", v, 32'h10);
    eng_busy = 1'b0;
    rd(4'd5, v); check(v[4] == 1'b0, "R13 busy clear", v, 0);

    // R3 / R8 receive order and level
    for (int i = 0; i < 7; i++) rx_deliver(32'hB0 + i);
    rd(4'd6, v); check(v[2] == 1'b0, "R8 rx level below 8", v, 0);
    rd(4'd5, v); check(v[2] == 1'b1, "R3 rx not empty", v, 32'h4);
    rx_deliver(32'hB7);
    rd(4'd6, v); check(v[2] == 1'b1, "R8 rx level at 8", v, 32'h4);
    for (int i = 0; i < 8; i++) rx_read("R3 rx order");
    rd(4'd5, v); check(v[2] == 1'b0, "R3 rx empty after reads", v, 0);

    // R4 / R5 full and overflow
    for (int i = 0; i < DEPTH; i++) rx_deliver(32'hC00 + i);
    rd(4'd5, v); check(v[3] == 1'b1, "R4 rx full", v, 32'h8);
    rd(4'd6, v); check(v[0] == 1'b0, "R5 no overflow yet", v, 0);
    rx_deliver(32'hDEAD);
    rd(4'd6, v); check(v[0] == 1'b1, "R5 overflow latched", v, 32'h1);
    for (int i = 0; i < DEPTH; i++) rx_read("R5 overflow word dropped");
    rd(4'd5, v); check(v[2] == 1'b0, "R5 rx empty after drain", v, 0);

    // R6 clear behaviour
    rd(4'd6, v); check(v[0] == 1'b1, "R6 overflow sticky", v, 32'h1);
    wr(4'd8, 32'hC);
    rd(4'd6, v); check(v[3] == 1'b1 && v[0] == 1'b1, "R6 level bits not clearable", v, 32'h9);
    wr(4'd8, 32'h1);
    rd(4'd6, v); check(v[0] == 1'b0, "R6 overflow cleared", v, 0);

    // R4 / R9 transmit full and code 7
    for (int i = 0; i < DEPTH; i++) tx_write(32'hE0 + i);
    rd(4'd5, v); check(v[1] == 1'b0, "R4 tx not-full clear", v, 0);
    rd(4'd6, v); check(v[3] == 1'b0, "R9 code 1 inactive at 16", v, 0);
    wr(4'd1, (32'd7 << 3) | (32'd2 << 9));
    rd(4'd6, v); check(v[3] == 1'b1, "R9 code 7 as 128", v, 32'h8);
    wr(4'd1, (32'd6 << 3) | (32'd2 << 9));
    rd(4'd6, v); check(v[3] == 1'b1, "R9 code 6 at 128", v, 32'h8);
    for (int i = 0; i < DEPTH; i++) tx_take("R4 tx drain order");

    // R11 timeout
    wr(4'd9, 32'd10);
    rx_deliver(32'hF1);
    repeat (5) @(negedge clk);
    rd(4'd6, v); check(v[1] == 1'b0, "R11 no timeout early", v, 0);
    repeat (12) @(negedge clk);
    rd(4'd6, v); check(v[1] == 1'b1, "R11 timeout latched", v, 32'h2);
    rx_read("R11 rx word");
    wr(4'd8, 32'h2);
    rd(4'd6, v); check(v[1] == 1'b0, "R11 timeout cleared", v, 0);
    wr(4'd9, 32'd0);
    rx_deliver(32'hF2);
    repeat (20) @(negedge clk);
    rd(4'd6, v); check(v[1] == 1'b0, "R11 limit zero disables", v, 0);

    // R12 disable flushes both queues
    rx_deliver(32'hF3);
    tx_write(32'h55);
    tx_write(32'h66);
    wr(4'd0, 0);
    rx_exp.delete(); tx_exp.delete(); m_rx = 0; m_tx = 0;
    expect_reg(4'd5, 32'h03, "R12 flushed while disabled");
    wr(4'd0, 1);
    expect_reg(4'd5, 32'h03, "R12 empty after re-enable");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule